// File: doc/BRIEF.md
# Sliced Counter-Block Incrementer

This block adds one to a 128-bit counter value, such as the initialization vector that advances between blocks in counter-mode encryption. It uses a single 16-bit adder. The adder is stepped across the value one slice per clock, starting with the least significant slice. The carry out of each slice is held in a register and added into the next slice. The result is the input value plus one, modulo 2^128.

A client presents a value and raises a request encoded as a 3-bit sparse code. The block loads the value and spends eight cycles on the slices. It then returns to idle, where it raises a one-cycle done code and holds the result on its output.

The control path is built to detect faults:
- Every state code of the controller is at least Hamming distance 3 from every other.
- Two-valued controls use 3-bit codes.
- A control code that is not valid, or a corrupted state register, traps the controller in an error state. Only reset leaves that state, and an alert output stays high while the controller is in it.

Top module: `sctr_inc`

## Requirements
- R1: While reset is active and after it is released, ready_o is 3'b011 (on), done_o is 3'b100 (off), alert_o is 0 and iv_o is all zeros.
- R2: When ready_o is on and req_i is 3'b011 at a rising edge, iv_i is captured. The value on iv_o at the done pulse equals the captured value plus one, modulo 2^128.
- R3: done_o shows 3'b011 for exactly one cycle. It appears after the eighth rising edge that follows the accepting edge. It is 3'b100 in every other cycle.
- R4: ready_o is 3'b100 for the eight cycles that follow an accepting edge. It returns to 3'b011 in the same cycle that done_o turns on.
- R5: The carry ripples upward through all eight 16-bit slices, least significant first. A value that is all ones wraps to all zeros, with no alert and no other effect.
- R6: A request that arrives while an increment is running is ignored. The result still derives from the value captured at acceptance, and no extra done pulse follows.
- R7: A code on req_i other than 3'b011 or 3'b100 sends the controller to its error state, from idle or mid-increment. The same holds for a state register value outside the three legal codes. In the error state alert_o is 1 from the next cycle on, ready_o and done_o are 3'b100, and requests are ignored.
- R8: Asserting rst_ni low clears the error state and restores the R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Sparse increment request: 3'b011 on, 3'b100 off |
| iv_i | input | 128 | Counter value to increment |
| ready_o | output | 3 | Sparse idle indication: 3'b011 on, 3'b100 off |
| done_o | output | 3 | Sparse one-cycle completion code |
| iv_o | output | 128 | Incremented value, valid from the done pulse on |
| alert_o | output | 1 | High while in the terminal error state |

## Verification
The accepting edge is counted as edge zero.
- Ready drops in the cycle after edge zero and stays off through the eighth cycle.
- Done and the result appear in the ninth cycle, after edge eight.
- Done is gone again one cycle later.
- An illegal request code raises the alert one cycle after the edge that samples it.

The bench steps on falling edges and checks every one of those cycles in its expected slot. It is never satisfied by a later wait. Random values are mixed with values whose carry stops at each slice boundary, and with the all-ones wrap.

// File: rtl/sctr_pkg.sv
package sctr_pkg;
  parameter int unsigned IvWidth    = 128;
  parameter int unsigned SliceWidth = 16;

  localparam int StateWidth = 5;
  typedef enum logic [StateWidth-1:0] {
    ST_IDLE  = 5'b01110,
    ST_INCR  = 5'b11000,
    ST_ERROR = 5'b00001
  } sctr_state_e;

  localparam int Sp2Width = 3;
  typedef enum logic [Sp2Width-1:0] {
    SP_ON  = 3'b011,
    SP_OFF = 3'b100
  } sp2_e;
endpackage

// File: rtl/sctr_sp2_dec.sv
module sctr_sp2_dec
  import sctr_pkg::*;
(
  input  logic [Sp2Width-1:0] code_i,
  output logic                on_o,
  output logic                bad_o
);
  assign on_o  = (code_i == SP_ON);
  assign bad_o = (code_i != SP_ON) && (code_i != SP_OFF);
endmodule

// File: rtl/sctr_slice_add.sv
module sctr_slice_add #(
  parameter int unsigned Width = 16
) (
  input  logic [Width-1:0] a_i,
  input  logic             cin_i,
  output logic [Width-1:0] sum_o,
  output logic             cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {{Width{1'b0}}, cin_i};
endmodule

// File: rtl/sctr_fsm.sv
module sctr_fsm
  import sctr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_on_i,
  input  logic req_bad_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic idle_o,
  output logic busy_o,
  output logic err_o
);
  logic [StateWidth-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_on_i) begin
          load_o  = 1'b1;
          state_d = ST_INCR;
        end
      end
      ST_INCR: begin
        step_o = 1'b1;
        if (last_i) begin
          fin_o   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_ERROR: state_d = ST_ERROR;
      default:  state_d = ST_ERROR;
    endcase
    // illegal control code overrides everything
    if (req_bad_i) begin
      state_d = ST_ERROR;
      load_o  = 1'b0;
      step_o  = 1'b0;
      fin_o   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign busy_o = (state_q == ST_INCR);
  assign err_o  = !idle_o && !busy_o;

  // R7
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) || (state_q == ST_INCR) || (state_q == ST_ERROR));

  // R7
  error_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR) |=> (state_q == ST_ERROR));
endmodule

// File: rtl/sctr_inc.sv
module sctr_inc
  import sctr_pkg::*;
#(
  parameter int unsigned IvW    = IvWidth,
  parameter int unsigned SliceW = SliceWidth
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [Sp2Width-1:0] req_i,
  input  logic [IvW-1:0]      iv_i,
  output logic [Sp2Width-1:0] ready_o,
  output logic [Sp2Width-1:0] done_o,
  output logic [IvW-1:0]      iv_o,
  output logic                alert_o
);
  localparam int unsigned NumSlices = IvW / SliceW;
  localparam int unsigned IdxW      = (NumSlices > 1) ? $clog2(NumSlices) : 1;
  localparam logic [IdxW-1:0] LastIdx = IdxW'(NumSlices - 1);

  logic            req_on, req_bad;
  logic            load, step, fin, idle, busy, err;
  logic [IdxW-1:0] idx_q;
  logic            carry_q;
  logic            done_q;
  logic [IvW-1:0]  iv_q;
  logic [SliceW-1:0] slice_val [NumSlices];
  logic [SliceW-1:0] cur_slice, sum_slice;
  logic              cout;
  logic              last;

  sctr_sp2_dec u_req_dec (
    .code_i (req_i),
    .on_o   (req_on),
    .bad_o  (req_bad)
  );

  assign last = (idx_q == LastIdx);

  sctr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_on_i  (req_on),
    .req_bad_i (req_bad),
    .last_i    (last),
    .load_o    (load),
    .step_o    (step),
    .fin_o     (fin),
    .idle_o    (idle),
    .busy_o    (busy),
    .err_o     (err)
  );

  for (genvar g = 0; g < NumSlices; g++) begin : g_slice
    assign slice_val[g] = iv_q[g*SliceW +: SliceW];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        iv_q[g*SliceW +: SliceW] <= '0;
      end else if (load) begin
        iv_q[g*SliceW +: SliceW] <= iv_i[g*SliceW +: SliceW];
      end else if (step && (idx_q == IdxW'(g))) begin
        iv_q[g*SliceW +: SliceW] <= sum_slice;
      end
    end
  end

  assign cur_slice = slice_val[idx_q];

  sctr_slice_add #(.Width(SliceW)) u_add (
    .a_i    (cur_slice),
    .cin_i  (carry_q),
    .sum_o  (sum_slice),
    .cout_o (cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      carry_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (load) begin
        idx_q   <= '0;
        carry_q <= 1'b1;
      end else if (step) begin
        idx_q   <= idx_q + IdxW'(1);
        carry_q <= cout;
      end
    end
  end

  assign ready_o = idle ? SP_ON : SP_OFF;
  assign done_o  = (done_q && !err) ? SP_ON : SP_OFF;
  assign iv_o    = iv_q;
  assign alert_o = err;

  // R4
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o == SP_ON && req_i == SP_ON) |=> (ready_o == SP_OFF));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o == SP_ON) |=> (done_o == SP_OFF));

  // R2
  first_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (idx_q == '0 && carry_q));

  // R5
  carry_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !carry_q && !last && !req_bad) |=> !carry_q);

  // R7
  alert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> (alert_o && ready_o == SP_OFF && done_o == SP_OFF));
endmodule

// File: tb/sctr_inc_bench.sv
module sctr_inc_bench;
  localparam logic [2:0] ON  = 3'b011;
  localparam logic [2:0] OFF = 3'b100;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   req_i = OFF;
  logic [127:0] iv_i = '0;
  logic [2:0]   ready_o, done_o;
  logic [127:0] iv_o;
  logic         alert_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sctr_inc u_sctr_inc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .iv_i    (iv_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .iv_o    (iv_o),
    .alert_o (alert_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [127:0] exp_inc(input logic [127:0] v);
    return v + 128'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_idle_reset(input string req);
    chk(ready_o == ON,  req, 128'(ready_o), 128'(ON));
    chk(done_o  == OFF, req, 128'(done_o),  128'(OFF));
    chk(alert_o == 1'b0, req, 128'(alert_o), 128'd0);
    chk(iv_o == '0, req, iv_o, '0);
  endtask

  // hammer: issue extra requests with junk data while busy (R6)
  task automatic run_inc(input logic [127:0] v, input bit hammer);
    logic [127:0] e;
    e = exp_inc(v);
    @(negedge clk_i);
    req_i = ON;
    iv_i  = v;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk_i);
      if (hammer && k < 8) begin
        req_i = ON;
        iv_i  = ~v ^ 128'(k);
      end else begin
        req_i = OFF;
      end
      // R4 busy window, R3 no early done
      chk(ready_o == OFF, "R4", 128'(ready_o), 128'(OFF));
      chk(done_o == OFF, "R3", 128'(done_o), 128'(OFF));
    end
    @(negedge clk_i);
    chk(done_o == ON, "R3", 128'(done_o), 128'(ON));
    chk(iv_o == e, hammer ? "R6" : "R2", iv_o, e);
    chk(ready_o == ON, "R4", 128'(ready_o), 128'(ON));
    chk(alert_o == 1'b0, "R5", 128'(alert_o), 128'd0);
    @(negedge clk_i);
    chk(done_o == OFF, "R3", 128'(done_o), 128'(OFF));
    if (hammer) begin
      @(negedge clk_i);
      chk(done_o == OFF && iv_o == e, "R6", iv_o, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_i  = OFF;
    @(negedge clk_i);
    chk_idle_reset("R8");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle_reset("R8");
  endtask

  initial begin
    logic [127:0] v;
    void'($urandom(32'h5c7a_0011));
    repeat (2) @(negedge clk_i);
    chk_idle_reset("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle_reset("R1");

    // directed corners
    run_inc(128'd0, 1'b0);
    run_inc('1, 1'b0);                                   // R5 wrap to zero
    for (int s = 1; s < 8; s++) begin                    // R5 carry stops at slice s
      v = (128'd1 << (16*s)) - 128'd1;
      run_inc(v, 1'b0);
    end
    run_inc({16'h1234, 16'hffff, 16'h0000, 16'hffff, 16'hffff, 16'h00ff, 16'hffff, 16'hffff}, 1'b0);

    // random
    for (int n = 0; n < 30; n++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 0) v[63:0] = '1;
      run_inc(v, n % 5 == 0);
    end

    // R6 directed
    run_inc(128'h0123_4567_89ab_cdef_ffff_ffff_ffff_ffff, 1'b1);

    // R7 illegal code while idle
    @(negedge clk_i);
    req_i = 3'b111;
    @(negedge clk_i);
    req_i = OFF;
    chk(alert_o == 1'b1, "R7", 128'(alert_o), 128'd1);
    chk(ready_o == OFF, "R7", 128'(ready_o), 128'(OFF));
    @(negedge clk_i);
    req_i = ON;
    iv_i  = 128'd5;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      chk(alert_o == 1'b1 && done_o == OFF && ready_o == OFF, "R7",
          {alert_o, done_o, ready_o}, {1'b1, OFF, OFF});
    end
    req_i = OFF;
    do_reset();
    run_inc(128'd41, 1'b0);

    // R7 illegal code mid-increment
    @(negedge clk_i);
    req_i = ON;
    iv_i  = 128'd77;
    @(negedge clk_i);
    req_i = OFF;
    @(negedge clk_i);
    req_i = 3'b000;
    @(negedge clk_i);
    req_i = OFF;
    chk(alert_o == 1'b1, "R7", 128'(alert_o), 128'd1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      chk(done_o == OFF && alert_o == 1'b1, "R7", {done_o, alert_o}, {OFF, 1'b1});
    end
    do_reset();
    run_inc('1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule